// File: doc/BRIEF.md
# Intercom Bus Serial Frame Receiver

This block takes the single-wire door-intercom bus after its voltage has been shifted to logic levels. It recovers the characters sent on that wire. The input is a synchronous digital signal. The receiver oversamples it sixteen times per bit cell, with a programmable clock divider setting the sample rate. It detects the falling edge that opens each character and checks that this start cell is still present at its centre. It then samples eight data bits and one parity bit, each at the centre of its cell. Parity is checked as odd, and any idle gap after the first stop cell is accepted.

Finished bytes leave on a valid/ready stream and carry two flags, one for a parity error and one for a framing error. The receiver cannot pause the wire, so it has no way to stall the line when the consumer applies back-pressure. The rule is as follows. The held byte and its flags stay stable until `out_ready` is seen high with `out_valid`. Any byte that completes while one is still pending is discarded. An end-of-message strobe marks a long idle gap after a character.

A separate debug output reports the length of every run on the line, in whole bit cells. A software decoder can use it to examine unknown traffic.

Top module: `ibus_rx`

## Requirements
- R1: A character is a start cell at logic 0, eight data cells sent least significant bit first, one parity cell and a stop cell. The decoded byte appears on `out_data`, and bit 0 of `out_data` is the first data cell received.
- R2: Parity is odd. `out_perr` is 1 when the data bits plus the parity bit hold an even number of ones. The byte is still delivered when this happens.
- R3: A logic-0 pulse that has ended by the centre of the start cell is rejected as a glitch, and no byte is produced.
- R4: When the first stop cell samples as logic 0, `out_ferr` is 1 on that byte. No new start is accepted until the line has returned to logic 1.
- R5: The gap between characters may be one, two or three stop cells, and every character is received in each case.
- R6: `eom` pulses for exactly one clock when logic 1 persists for 12 bit cells after the centre of the last stop cell. It pulses at most once per gap, and not at all for gaps of three cells or less.
- R7: With `invert`=1, a high wire is logic 0. With `invert`=0, a high wire is logic 1.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and the flags hold their values. A byte that finishes while another is pending is dropped.
- R9: One clock after each change of logic level, `run_stb` pulses. At the same time `run_len` gives the length of the run that just ended, in bit cells rounded to the nearest whole cell, saturating at 15.
- R10: During and after reset, `out_valid`, `eom` and `run_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Bus wire, already at logic levels |
| invert | input | 1 | 1: a high wire means logic 0 |
| out_valid | output | 1 | A byte is held |
| out_ready | input | 1 | The consumer accepts the held byte |
| out_data | output | 8 | Decoded byte |
| out_perr | output | 1 | Odd-parity check failed |
| out_ferr | output | 1 | First stop cell was logic 0 |
| eom | output | 1 | End-of-message strobe |
| run_stb | output | 1 | A run has ended |
| run_len | output | 4 | Length of the ended run, in bit cells |

## Verification
The hardest state to reach from the ports is the pending-byte drop. It needs `out_ready` held low across two whole characters, after which the held byte must come out and the later one must not. The bench reaches the end-of-message condition only by an exact idle length, so it runs the short gaps of a vector sequence before one long gap. Polarity changes are made between characters, with the wire flipped in the same cycle, so that no false start appears. Runs of fractional and saturating length are driven directly at the pin to exercise the rounding and the clamp at 15.

// File: rtl/ibus_pkg.sv
package ibus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAITHI
  } rx_state_t;
endpackage

// File: rtl/ibus_tick.sv
module ibus_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV == 1) begin : g_every
      assign tick = rst_n;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      logic [W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt  <= '0;
          tick <= 1'b0;
        end else if (cnt == W'(DIV - 1)) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt  <= cnt + 1'b1;
          tick <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ibus_frame.sv
module ibus_frame
  import ibus_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int EOM_CELLS = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       lvl,
  output logic       byte_stb,
  output logic [7:0] byte_data,
  output logic       byte_perr,
  output logic       byte_ferr,
  output logic       eom
);
  localparam int CW      = $clog2(OVS);
  localparam int HALF    = OVS / 2 - 1;
  localparam int FULL    = OVS - 1;
  localparam int GAP_LIM = EOM_CELLS * OVS;
  localparam int GW      = $clog2(GAP_LIM + 1);

  rx_state_t    state;
  logic [CW-1:0] cnt;
  logic [2:0]   bitidx;
  logic [7:0]   shreg;
  logic         par_bit;
  logic [GW-1:0] gap;
  logic         armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bitidx    <= '0;
      shreg     <= '0;
      par_bit   <= 1'b0;
      gap       <= '0;
      armed     <= 1'b0;
      byte_stb  <= 1'b0;
      byte_data <= '0;
      byte_perr <= 1'b0;
      byte_ferr <= 1'b0;
      eom       <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      eom      <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_IDLE: begin
            if (!lvl) begin
              state <= ST_START;
              cnt   <= '0;
            end else if (gap == GW'(GAP_LIM)) begin
              if (armed) eom <= 1'b1;
              armed <= 1'b0;
            end else begin
              gap <= gap + 1'b1;
            end
          end
          ST_START: begin
            if (cnt == CW'(HALF)) begin
              cnt <= '0;
              if (lvl) begin
                state <= ST_IDLE;
                gap   <= '0;
              end else begin
                state  <= ST_DATA;
                bitidx <= '0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == CW'(FULL)) begin
              cnt   <= '0;
              shreg <= {lvl, shreg[7:1]};
              if (bitidx == 3'd7) state <= ST_PAR;
              else bitidx <= bitidx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt == CW'(FULL)) begin
              cnt     <= '0;
              par_bit <= lvl;
              state   <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt == CW'(FULL)) begin
              cnt       <= '0;
              byte_stb  <= 1'b1;
              byte_data <= shreg;
              byte_perr <= ~(^{shreg, par_bit});
              byte_ferr <= ~lvl;
              armed     <= 1'b1;
              gap       <= '0;
              state     <= lvl ? ST_IDLE : ST_WAITHI;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_WAITHI: begin
            if (lvl) begin
              state <= ST_IDLE;
              gap   <= '0;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: a start cell that is back at idle by its centre returns to idle
  a_r3_glitch_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && tick && cnt == CW'(HALF) && lvl) |=> (state == ST_IDLE));

  // R1: exactly eight data cells precede the parity cell
  a_r1_eight_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && tick && cnt == CW'(FULL) && bitidx == 3'd7) |=> (state == ST_PAR));

  // R6: end-of-message is a single-cycle strobe
  a_r6_eom_single: assert property (@(posedge clk) disable iff (!rst_n)
    eom |=> !eom);
endmodule

// File: rtl/ibus_runlen.sv
module ibus_runlen #(
  parameter int BIT_CLKS = 32,
  parameter int RUN_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  output logic             run_stb,
  output logic [RUN_W-1:0] run_len
);
  localparam int CW  = $clog2(BIT_CLKS);
  localparam int SAT = (1 << RUN_W) - 1;

  logic [CW-1:0]    ccnt;
  logic [RUN_W-1:0] cells;
  logic             lvl_q;
  logic [RUN_W:0]   rounded;
  logic [RUN_W-1:0] run_val;

  always_comb begin
    rounded = {1'b0, cells} + ((ccnt >= CW'(BIT_CLKS / 2)) ? (RUN_W+1)'(1) : (RUN_W+1)'(0));
    run_val = (rounded > (RUN_W+1)'(SAT)) ? RUN_W'(SAT) : rounded[RUN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccnt    <= '0;
      cells   <= '0;
      lvl_q   <= 1'b1;
      run_stb <= 1'b0;
      run_len <= '0;
    end else begin
      lvl_q   <= lvl;
      run_stb <= 1'b0;
      if (lvl != lvl_q) begin
        run_stb <= 1'b1;
        run_len <= run_val;
        ccnt    <= CW'(1);
        cells   <= '0;
      end else if (ccnt == CW'(BIT_CLKS - 1)) begin
        ccnt <= '0;
        if (cells != RUN_W'(SAT)) cells <= cells + 1'b1;
      end else begin
        ccnt <= ccnt + 1'b1;
      end
    end
  end

  // R9: the cell count never wraps past saturation
  a_r9_cells_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (cells == RUN_W'(SAT) && lvl == lvl_q) |=> (cells == RUN_W'(SAT)));
endmodule

// File: rtl/ibus_rx.sv
module ibus_rx #(
  parameter int CLKS_PER_TICK = 2,
  parameter int OVS           = 16,
  parameter int EOM_CELLS     = 12,
  parameter int RUN_W         = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  input  logic             invert,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_perr,
  output logic             out_ferr,
  output logic             eom,
  output logic             run_stb,
  output logic [RUN_W-1:0] run_len
);
  localparam int BIT_CLKS = CLKS_PER_TICK * OVS;

  logic       lvl;
  logic       tick;
  logic       byte_stb;
  logic [7:0] byte_data;
  logic       byte_perr;
  logic       byte_ferr;

  assign lvl = line_in ^ invert;

  ibus_tick #(.DIV(CLKS_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  ibus_frame #(.OVS(OVS), .EOM_CELLS(EOM_CELLS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lvl(lvl),
    .byte_stb(byte_stb), .byte_data(byte_data),
    .byte_perr(byte_perr), .byte_ferr(byte_ferr), .eom(eom)
  );

  ibus_runlen #(.BIT_CLKS(BIT_CLKS), .RUN_W(RUN_W)) u_run (
    .clk(clk), .rst_n(rst_n), .lvl(lvl),
    .run_stb(run_stb), .run_len(run_len)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_perr  <= 1'b0;
      out_ferr  <= 1'b0;
    end else if (byte_stb && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_data  <= byte_data;
      out_perr  <= byte_perr;
      out_ferr  <= byte_ferr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a held byte stays put under back-pressure
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_perr) && $stable(out_ferr)));
endmodule

// File: tb/ibus_rx_test.sv
module ibus_rx_test;
  localparam int BIT = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_in = 1'b0;
  logic       invert = 1'b1;
  logic       out_ready = 1'b1;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_perr;
  logic       out_ferr;
  logic       eom;
  logic       run_stb;
  logic [3:0] run_len;

  always #10 clk = ~clk;

  ibus_rx uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .invert(invert),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_perr(out_perr), .out_ferr(out_ferr), .eom(eom),
    .run_stb(run_stb), .run_len(run_len)
  );

  int nchk = 0;
  int nfail = 0;
  int nbytes = 0;
  int nrun = 0;
  int eom_cnt = 0;
  logic [7:0] cap_data [64];
  logic       cap_perr [64];
  logic       cap_ferr [64];
  logic [3:0] cap_run  [64];

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready && nbytes < 64) begin
        cap_data[nbytes] = out_data;
        cap_perr[nbytes] = out_perr;
        cap_ferr[nbytes] = out_ferr;
        nbytes++;
      end
      if (eom) eom_cnt++;
      if (run_stb && nrun < 64) begin
        cap_run[nrun] = run_len;
        nrun++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // vector fields: [12:5] data, [4] bad parity, [3] bad stop, [2:1] stop cells, [0] invert
  localparam logic [12:0] VEC [8] = '{
    {8'hFF, 1'b0, 1'b0, 2'd1, 1'b1},
    {8'h73, 1'b0, 1'b0, 2'd3, 1'b1},
    {8'hA9, 1'b0, 1'b0, 2'd2, 1'b1},
    {8'h77, 1'b1, 1'b0, 2'd2, 1'b1},
    {8'h00, 1'b0, 1'b1, 2'd2, 1'b1},
    {8'h5A, 1'b0, 1'b0, 2'd3, 1'b0},
    {8'h01, 1'b1, 1'b0, 2'd1, 1'b0},
    {8'h80, 1'b0, 1'b0, 2'd2, 1'b0}
  };

  // entered and left just after a rising edge
  task automatic hold(input logic l, input int n);
    #1 line_in = l ^ invert;
    repeat (n) @(posedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic bp, input logic bs,
                            input int stops);
    hold(1'b0, BIT);
    for (int i = 0; i < 8; i++) hold(d[i], BIT);
    hold((~^d) ^ bp, BIT);
    hold(~bs, BIT);
    for (int k = 1; k < stops; k++) hold(1'b1, BIT);
  endtask

  localparam int RUNX [6] = '{15, 3, 5, 1, 15, 2};

  initial begin
    int n0, e0, r0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R10 valid in reset", int'(out_valid), 0);
    check("R10 eom in reset", int'(eom), 0);
    check("R10 run_stb in reset", int'(run_stb), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R10 valid after reset", int'(out_valid), 0);
    @(posedge clk);
    hold(1'b1, 20 * BIT);

    // vector walk: R1 R2 R4 R5 R7, short gaps for R6
    n0 = nbytes;
    e0 = eom_cnt;
    for (int v = 0; v < 8; v++) begin
      if (invert != VEC[v][0]) begin
        #1 invert = VEC[v][0];
        line_in = 1'b1 ^ VEC[v][0];
        @(posedge clk);
      end
      send_frame(VEC[v][12:5], VEC[v][4], VEC[v][3], int'(VEC[v][2:1]));
    end
    check("R6 no eom on short gaps", eom_cnt - e0, 0);
    hold(1'b1, 14 * BIT);
    check("R5 byte count", nbytes - n0, 8);
    for (int v = 0; v < 8; v++) begin
      check("R1 R7 data", int'(cap_data[n0 + v]), int'(VEC[v][12:5]));
      check("R2 parity flag", int'(cap_perr[n0 + v]), int'(VEC[v][4]));
      check("R4 framing flag", int'(cap_ferr[n0 + v]), int'(VEC[v][3]));
    end
    check("R6 eom after long gap", eom_cnt - e0, 1);
    hold(1'b1, 20 * BIT);
    check("R6 eom once per gap", eom_cnt - e0, 1);

    // R3: short low pulse
    n0 = nbytes;
    hold(1'b0, 6);
    hold(1'b1, 14 * BIT);
    check("R3 glitch gives no byte", nbytes - n0, 0);

    // R8: back-pressure
    n0 = nbytes;
    #1 out_ready = 1'b0;
    send_frame(8'h3C, 1'b0, 1'b0, 2);
    send_frame(8'hC3, 1'b0, 1'b0, 2);
    hold(1'b1, 2 * BIT);
    @(negedge clk);
    check("R8 valid held", int'(out_valid), 1);
    check("R8 first byte held", int'(out_data), 'h3C);
    @(posedge clk);
    #1 out_ready = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R8 one byte delivered", nbytes - n0, 1);
    check("R8 delivered value", int'(cap_data[n0]), 'h3C);
    check("R8 second byte dropped", int'(out_valid), 0);
    @(posedge clk);

    // R9: run lengths incl. rounding and saturation
    hold(1'b1, 20 * BIT);
    r0 = nrun;
    hold(1'b0, 96);
    hold(1'b1, 160);
    hold(1'b0, 40);
    hold(1'b1, 640);
    hold(1'b0, 48);
    hold(1'b1, 20 * BIT);
    check("R9 run count", nrun - r0, 6);
    for (int i = 0; i < 6; i++)
      check("R9 run length", int'(cap_run[r0 + i]), RUNX[i]);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule